// File: doc/BRIEF.md
# Data-Ready Triggered SPI Conversion Reader

This block is an SPI master that collects 24-bit results from a delta-sigma converter left in continuous-read mode. It sits idle until the converter's active-low data-ready line falls. It then pulls chip select low and waits a configurable setup gap. After that it clocks in three bytes, most significant bit first, while the data line toward the converter stays low. It holds chip select low for a configurable hold time, releases it, and presents the assembled word with a single-cycle strobe.

At the end of every read the block checks the data-ready line. A converter that took the first byte for a command waits for a fourth byte, so its data-ready stays low. The block reports this case through a sticky error flag. The SCLK half period, the setup gap and the hold time are parameters counted in system clock cycles. The SPI mode is CPOL=0, and the block samples the converter's data on each falling SCLK edge.

The controller is a five-state machine:
- `ST_IDLE`: chip select high, SCLK low. A synchronised data-ready fall moves it to `ST_SETUP`.
- `ST_SETUP`: chip select low. After `SETUP_CYC` cycles it starts the shifter and moves to `ST_SHIFT`.
- `ST_SHIFT`: 24 SCLK periods. The shifter's done pulse moves it to `ST_HOLD`.
- `ST_HOLD`: chip select still low. After `HOLD_CYC` cycles it moves to `ST_DONE`.
- `ST_DONE`: one cycle. Chip select rises, the result and strobe appear, and the error flag is updated. It always returns to `ST_IDLE`.

Top module: `drdy_spi_reader`

## Requirements
- R1: A read starts only on a falling edge of `drdy_n_i` after a two-flop synchroniser. A line that is already low when reset is released, or that stays low, starts nothing.
- R2: Data-ready edges that arrive while a read is running are ignored. Each read produces exactly one result strobe.
- R3: `mosi_o` is 0 at all times.
- R4: At least `SETUP_CYC` system cycles pass from `cs_n_o` falling to the first rising edge of `sclk_o`. `sclk_o` is never high while `cs_n_o` is high.
- R5: Each read has 24 SCLK periods, CPOL=0. Each high phase and each low phase lasts `SCLK_HALF` cycles. `miso_i` is sampled on the falling edge, and the first bit sampled becomes bit 23 of the result.
- R6: At least `HOLD_CYC` cycles pass from the last falling SCLK edge to `cs_n_o` rising. In the cycle `cs_n_o` rises, `result_o` holds the new word and `result_valid_o` is high for exactly one cycle.
- R7: If the synchronised data-ready is still low at the end of the hold time, `frame_err_o` rises together with the result strobe. It stays high until reset, and later good reads do not clear it.
- R8: After reset, `cs_n_o` is 1 and `sclk_o`, `result_valid_o`, `frame_err_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n_i | input | 1 | Converter data-ready, active low, asynchronous |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the converter, held low |
| result_o | output | 24 | Last conversion word |
| result_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | Sticky flag: data-ready still low after a read |

## Verification
The result strobe and the rise of the sticky error flag land in the same `ST_DONE` cycle. To provoke this, the converter model keeps data-ready low after the 24th falling SCLK edge of one frame. The scoreboard item for that frame expects the correct word and the flag set in that same cycle. Every later item expects the flag to stay set. A second frame toggles data-ready in the middle of its transfer, so a new edge coincides with an active shift. For that frame the bench expects no extra strobe and no change to the shifted word.

// File: rtl/drdy_rd_pkg.sv
package drdy_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_DONE
    } rd_state_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/drdy_edge_sync.sv
module drdy_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_n_i};
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign fall_o  = pipe_q[STAGES] & ~pipe_q[STAGES-1];

    // R1: a detected edge is a single-cycle event
    assert_fall_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
    import drdy_rd_pkg::*;
#(
    parameter int BITS      = 24,
    parameter int SCLK_HALF = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            miso_i,
    output logic            sclk_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [BITS-1:0] data_o
);
    localparam int HW = cnt_w(SCLK_HALF);
    localparam int BW = cnt_w(BITS);

    logic            active_q;
    logic            sclk_q;
    logic            done_q;
    logic [HW-1:0]   half_q;
    logic [BW-1:0]   bit_q;
    logic [BITS-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            shreg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b1;
                half_q   <= '0;
                bit_q    <= '0;
            end else if (active_q) begin
                if (half_q == HW'(SCLK_HALF - 1)) begin
                    half_q <= '0;
                    sclk_q <= ~sclk_q;
                    if (sclk_q) begin
                        shreg_q <= {shreg_q[BITS-2:0], miso_i};
                        if (bit_q == BW'(BITS - 1)) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign busy_o = active_q;
    assign done_o = done_q;
    assign data_o = shreg_q;

    // R2: no restart while shifting
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active_q);
    // R5: the word completes on a falling edge, SCLK left low
    assert_done_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !sclk_q);
    // R5: SCLK only toggles inside a shift
    assert_sclk_in_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> active_q);
endmodule

// File: rtl/drdy_spi_reader.sv
module drdy_spi_reader
    import drdy_rd_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int SCLK_HALF = 50,
    parameter int SETUP_CYC = 12,
    parameter int HOLD_CYC  = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_n_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              frame_err_o
);
    localparam int CMAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = cnt_w(CMAX);

    rd_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic              drdy_lvl, drdy_fall;
    logic              sh_start, sh_busy, sh_done;
    logic [DATA_W-1:0] sh_data;
    logic              setup_last, hold_last;
    logic              cs_n_q, valid_q, err_q;
    logic [DATA_W-1:0] result_q;

    drdy_edge_sync #(.STAGES(2)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (drdy_n_i),
        .level_o   (drdy_lvl),
        .fall_o    (drdy_fall)
    );

    spi_rx_shifter #(.BITS(DATA_W), .SCLK_HALF(SCLK_HALF)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .miso_i  (miso_i),
        .sclk_o  (sclk_o),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .data_o  (sh_data)
    );

    assign setup_last = (cnt_q == CW'(SETUP_CYC - 1));
    assign hold_last  = (cnt_q == CW'(HOLD_CYC - 1));
    assign sh_start   = (state_q == ST_SETUP) && setup_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (drdy_fall)  state_d = ST_SETUP;
            ST_SETUP: if (setup_last) state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done)    state_d = ST_HOLD;
            ST_HOLD:  if (hold_last)  state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_DONE);
            valid_q <= (state_d == ST_DONE);
            if (state_d == ST_DONE) begin
                result_q <= sh_data;
                if (!drdy_lvl) err_q <= 1'b1;
            end
        end
    end

    assign cs_n_o         = cs_n_q;
    assign mosi_o         = 1'b0;
    assign result_o       = result_q;
    assign result_valid_o = valid_q;
    assign frame_err_o    = err_q;

    // R4: SCLK only toggles under an asserted chip select
    assert_sclk_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    // R6: result strobe coincides with chip select released
    assert_valid_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> cs_n_o);
    // R6: strobe lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);
    // R7: the error flag rises only with a result
    assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> result_valid_o);
    // R2: the shifter is never running while idle
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sh_busy);
endmodule

// File: tb/drdy_spi_reader_tb.sv
module drdy_spi_reader_tb_top;
    localparam int DW    = 24;
    localparam int HALF  = 4;
    localparam int SETUP = 12;
    localparam int HOLD  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          drdy_n = 1'b0;
    logic          miso = 1'b0;
    logic          sclk, cs_n, mosi, valid, err;
    logic [DW-1:0] result;

    int checks = 0;
    int fails  = 0;
    int valids = 0;
    int frames = 0;
    bit done_flag = 0;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          err;
    } exp_t;
    exp_t exp_q[$];
    logic exp_err = 1'b0;

    always #2.5 clk = ~clk;

    drdy_spi_reader #(.DATA_W(DW), .SCLK_HALF(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .drdy_n_i       (drdy_n),
        .miso_i         (miso),
        .sclk_o         (sclk),
        .cs_n_o         (cs_n),
        .mosi_o         (mosi),
        .result_o       (result),
        .result_valid_o (valid),
        .frame_err_o    (err)
    );

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    // converter model driver
    task automatic frame(input logic [DW-1:0] word, input bit keep_low, input bit glitch);
        exp_t it;
        if (keep_low) exp_err = 1'b1;
        it.data = word;
        it.err  = exp_err;
        exp_q.push_back(it);
        frames++;
        @(negedge clk);
        drdy_n = 1'b1;
        repeat (5) @(negedge clk);
        drdy_n = 1'b0;
        @(negedge cs_n);
        for (int i = 0; i < DW; i++) begin
            @(posedge sclk);
            #1 miso = word[DW-1-i];
            if (glitch && i == 6) begin
                @(negedge clk) drdy_n = 1'b1;
                @(negedge clk) drdy_n = 1'b0;
            end
            @(negedge sclk);
        end
        if (!keep_low) drdy_n = 1'b1;
        @(posedge cs_n);
        repeat (8) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid) begin
            valids++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result strobe");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(result == e.data, "R5",
                      $sformatf("data actual=%h expected=%h", result, e.data));
                check(err == e.err, "R7",
                      $sformatf("err actual=%0b expected=%0b", err, e.err));
                check(cs_n == 1'b1, "R6", $sformatf("cs_n actual=%0b expected=1", cs_n));
            end
        end
    end

    // pin timing monitor
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    int   setup_cnt = 0, hold_cnt = 0, hi_run = 0, lo_run = 0;
    bit   first_rise = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mosi !== 1'b0) check(1'b0, "R3", $sformatf("mosi actual=%b expected=0", mosi));
            if (sclk && cs_n) check(1'b0, "R4", "sclk actual=1 expected=0 with cs_n high");
            if (prev_cs && !cs_n) begin
                setup_cnt = 0;
                first_rise = 1'b1;
            end else setup_cnt++;
            if (!prev_sclk && sclk) begin
                if (first_rise)
                    check(setup_cnt >= SETUP, "R4",
                          $sformatf("setup actual=%0d expected>=%0d", setup_cnt, SETUP));
                else
                    check(lo_run == HALF, "R5",
                          $sformatf("low phase actual=%0d expected=%0d", lo_run, HALF));
                first_rise = 1'b0;
            end
            if (prev_sclk && !sclk) begin
                check(hi_run == HALF, "R5",
                      $sformatf("high phase actual=%0d expected=%0d", hi_run, HALF));
                hold_cnt = 0;
            end else hold_cnt++;
            if (!prev_cs && cs_n)
                check(hold_cnt >= HOLD, "R6",
                      $sformatf("hold actual=%0d expected>=%0d", hold_cnt, HOLD));
            hi_run = sclk ? ((prev_sclk ? hi_run : 0) + 1) : hi_run;
            lo_run = (!sclk) ? ((!prev_sclk ? lo_run : 0) + 1) : lo_run;
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && valid == 1'b0 && err == 1'b0 && result == '0, "R8",
              $sformatf("reset cs=%b sclk=%b v=%b e=%b r=%h expected 1 0 0 0 0",
                        cs_n, sclk, valid, err, result));
        rst_n = 1'b1;
        // R1: line low from reset, no edge -> no read
        repeat (100) @(negedge clk);
        check(cs_n == 1'b1 && valids == 0, "R1",
              $sformatf("idle cs_n actual=%b expected=1 strobes=%0d", cs_n, valids));

        frame(24'hA5C30F, 1'b0, 1'b0);
        frame(24'h000000, 1'b0, 1'b0);
        frame(24'hFFFFFF, 1'b0, 1'b0);
        frame(24'h800001, 1'b0, 1'b0);
        frame(24'h5A5A5A, 1'b0, 1'b1);   // R2 mid-transfer edge
        repeat (50) @(negedge clk);
        check(valids == frames && cs_n == 1'b1, "R2",
              $sformatf("strobes actual=%0d expected=%0d", valids, frames));
        check(err == 1'b0, "R7", $sformatf("err actual=%b expected=0", err));
        frame(24'h123456, 1'b1, 1'b0);   // R7 stuck low
        check(err == 1'b1, "R7", $sformatf("err actual=%b expected=1", err));
        frame(24'h0F0F0F, 1'b0, 1'b0);   // R7 stays sticky
        check(err == 1'b1, "R7", $sformatf("err sticky actual=%b expected=1", err));
        check(exp_q.size() == 0 && valids == frames, "R6",
              $sformatf("pending=%0d strobes=%0d expected=%0d", exp_q.size(), valids, frames));

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(err == 1'b0 && cs_n == 1'b1, "R8",
              $sformatf("after reset err=%b cs_n=%b expected 0 1", err, cs_n));
        finish_run();
    end
endmodule